// File: doc/BRIEF.md
# Active-Low Status Flag Register

This block holds an 8-bit status byte whose fault flags rest at 1 and drop to 0 when something goes wrong. Single-cycle event pulses from the surrounding monitors drive the flags low:
- supply undervoltage,
- reference undervoltage,
- register-map CRC mismatch,
- internal memory fault.

Software restores a clearable flag by writing 1 to its bit at the status address. The memory fault flag can only be restored by a device reset. A separate flag records whether the most recent register write went to a legal target, and it is re-evaluated on every write. Bit 0 passes the data-ready level straight through.

The block also decodes a reset command written to the control address. It treats that command, or a device-reset event pulse, as a device reset. A device reset returns the byte to 3Eh and raises a one-cycle request to the rest of the chip. The `fault_n` pin combines the supply, reference, CRC and memory flags into a single active-low fault pin.

The register port is a plain single-cycle strobe interface with no back-pressure. A write is taken on every rising edge where `wr_en` is high. Read data is combinational from `addr`.

Top module: `actlow_status_reg`

## Requirements
- R1: After `rst_n` is released, the status byte reads 3Eh with `drdy_i` low. Its layout from bit 7 down is:
  - bit 7: reset flag
  - bit 6: supply flag
  - bit 5: reference flag
  - bit 4: reserved
  - bit 3: CRC flag
  - bit 2: memory flag
  - bit 1: bad-write flag
  - bit 0: data-ready
- R2: Bit 4 always reads 1, and bit 0 always equals `drdy_i` in the same cycle.
- R3: A write to address 02h sets each of bits 7, 6, 5 and 3 to 1 where the written bit is 1. Bits written as 0 leave their flag unchanged.
- R4: An `evt_mem_fault` pulse drives bit 2 to 0. Bit 2 stays 0, whatever is written to 02h, until a device reset.
- R5: Every write re-evaluates bit 1. The bit becomes 1 for a write to 02h or to any address from 04h to 0Fh. It becomes 0 for a write to 00h, 01h, 03h or any address above 0Fh. Cycles without `wr_en` never change it.
- R6: While `pwrdn` is high, bit 6 is forced to 0 on every clock, even against a write-1 restore.
- R7: `fault_n` is 0 exactly when any of bits 6, 5, 3 or 2 is 0.
- R8: Writing 58h to address 04h is the reset command: 010110b in bits 7:2, with bits 1:0 both 0. One cycle later, `rst_req_o` is high for one cycle and the status byte is back to 3Eh. Writing other values to 04h, such as 59h or 5Ah, causes neither effect.
- R9: Reads return 00h at every address other than 02h, including the control address 04h.
- R10: In a cycle where a flag's event input is high, that flag ends at 0 even if the same cycle writes 1 to its bit. A device reset in the same cycle overrides every event.
- R11: An `evt_dev_reset` pulse has the same effect on the status byte as the reset command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle while high |
| addr | input | ADDR_W | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| drdy_i | input | 1 | Data-ready level, mirrored in bit 0 |
| evt_dev_reset | input | 1 | Device-reset event pulse |
| evt_supply_uv | input | 1 | Supply undervoltage event pulse |
| evt_ref_uv | input | 1 | Reference undervoltage event pulse |
| evt_crc_fault | input | 1 | Register-map CRC mismatch pulse |
| evt_mem_fault | input | 1 | Internal memory fault pulse |
| pwrdn | input | 1 | Power-down level |
| fault_n | output | 1 | Combined active-low fault pin |
| rst_req_o | output | 1 | One-cycle device-reset request after the reset command |

## Verification
The bench builds the block with its default parameters:
- an 8-bit address,
- status at 02h and control at 04h,
- legal write targets from 04h to 0Fh,
- reset code 010110b.

The 8-bit address lets the bench write above 0Fh, so the bad-write flag is exercised both inside and beyond the register window. The fixed status and control addresses let the bench collide a write-1 restore with an event in the same cycle, and a reset with events. They also let it tell the exact reset command apart from near-miss codes whose low two bits are not zero.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
  localparam int BIT_RST = 7;
  localparam int BIT_SUP = 6;
  localparam int BIT_REF = 5;
  localparam int BIT_RSV = 4;
  localparam int BIT_CRC = 3;
  localparam int BIT_MEM = 2;
  localparam int BIT_WRF = 1;
  localparam int BIT_RDY = 0;

  localparam int NFLAG = 5;
  localparam logic [7:0] STAT_RESET = 8'h3E;

  typedef struct packed {
    logic stat_wr;
    logic wr_legal;
    logic rst_cmd;
    logic rd_stat;
  } dec_t;

  function automatic int flag_pos(input int i);
    case (i)
      0: flag_pos = BIT_RST;
      1: flag_pos = BIT_SUP;
      2: flag_pos = BIT_REF;
      3: flag_pos = BIT_CRC;
      default: flag_pos = BIT_MEM;
    endcase
  endfunction
endpackage

// File: rtl/lfs_addr_decode.sv
module lfs_addr_decode
  import lfs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int STAT_ADDR = 2,
  parameter int CTRL_ADDR = 4,
  parameter int WR_HI = 15,
  parameter logic [5:0] RST_CODE = 6'b010110
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output dec_t              dec
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(WR_HI);
  localparam logic [7:0]        CMD    = {RST_CODE, 2'b00};

  logic hit_stat, hit_ctrl, in_window;

  always_comb begin
    hit_stat  = (addr == A_STAT);
    hit_ctrl  = (addr == A_CTRL);
    in_window = (addr >= A_CTRL) && (addr <= A_HI);
    dec.rd_stat  = hit_stat;
    dec.stat_wr  = wr_en && hit_stat;
    dec.wr_legal = hit_stat || in_window;
    dec.rst_cmd  = wr_en && hit_ctrl && (wdata == CMD);
  end
endmodule

// File: rtl/lfs_flag_cell.sv
module lfs_flag_cell #(
  parameter logic RST_VAL = 1'b1,
  parameter bit   CLEARABLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic evt,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q <= RST_VAL;
    else if (soft_rst)         q <= RST_VAL;
    else if (evt)              q <= 1'b0;
    else if (CLEARABLE && clr) q <= 1'b1;
  end
endmodule

// File: rtl/actlow_status_reg.sv
module actlow_status_reg
  import lfs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int STAT_ADDR = 2,
  parameter int CTRL_ADDR = 4,
  parameter int WR_HI = 15,
  parameter logic [5:0] RST_CODE = 6'b010110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              drdy_i,
  input  logic              evt_dev_reset,
  input  logic              evt_supply_uv,
  input  logic              evt_ref_uv,
  input  logic              evt_crc_fault,
  input  logic              evt_mem_fault,
  input  logic              pwrdn,
  output logic              fault_n,
  output logic              rst_req_o
);
  dec_t             dec;
  logic             soft_rst;
  logic [NFLAG-1:0] evt_vec;
  logic [NFLAG-1:0] flag_q;
  logic             wrf_q;
  logic [7:0]       stat_q;

  lfs_addr_decode #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .CTRL_ADDR(CTRL_ADDR),
    .WR_HI(WR_HI), .RST_CODE(RST_CODE)
  ) u_dec (
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .dec(dec)
  );

  assign soft_rst = dec.rst_cmd || evt_dev_reset;

  // event sources in flag order: reset, supply, reference, crc, memory
  assign evt_vec = {evt_mem_fault, evt_crc_fault, evt_ref_uv,
                    evt_supply_uv || pwrdn, 1'b0};

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    localparam int POS = flag_pos(i);
    lfs_flag_cell #(
      .RST_VAL(STAT_RESET[POS]),
      .CLEARABLE(POS != BIT_MEM)
    ) u_cell (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .evt(evt_vec[i]),
      .clr(dec.stat_wr && wdata[POS]),
      .q(flag_q[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wrf_q <= STAT_RESET[BIT_WRF];
    else if (soft_rst) wrf_q <= STAT_RESET[BIT_WRF];
    else if (wr_en)    wrf_q <= dec.wr_legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req_o <= 1'b0;
    else        rst_req_o <= dec.rst_cmd;
  end

  always_comb begin
    stat_q          = 8'h00;
    stat_q[BIT_RST] = flag_q[0];
    stat_q[BIT_SUP] = flag_q[1];
    stat_q[BIT_REF] = flag_q[2];
    stat_q[BIT_CRC] = flag_q[3];
    stat_q[BIT_MEM] = flag_q[4];
    stat_q[BIT_RSV] = 1'b1;
    stat_q[BIT_WRF] = wrf_q;
    stat_q[BIT_RDY] = drdy_i;
  end

  assign fault_n = flag_q[1] & flag_q[2] & flag_q[3] & flag_q[4];
  assign rdata   = dec.rd_stat ? stat_q : 8'h00;
endmodule

// File: rtl/actlow_status_chk.sv
module actlow_status_chk #(
  parameter int ADDR_W = 8,
  parameter int STAT_ADDR = 2,
  parameter int CTRL_ADDR = 4,
  parameter int WR_HI = 15,
  parameter logic [5:0] RST_CODE = 6'b010110
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              drdy_i,
  input logic              evt_dev_reset,
  input logic              evt_ref_uv,
  input logic              evt_mem_fault,
  input logic              pwrdn,
  input logic              fault_n,
  input logic              rst_req_o,
  input logic [7:0]        stat_q
);
  logic cmd, legal, srst;
  assign cmd   = wr_en && (addr == ADDR_W'(CTRL_ADDR)) && (wdata == {RST_CODE, 2'b00});
  assign legal = (addr == ADDR_W'(STAT_ADDR)) ||
                 ((addr >= ADDR_W'(CTRL_ADDR)) && (addr <= ADDR_W'(WR_HI)));
  assign srst  = cmd || evt_dev_reset;

  AST_STAT_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(STAT_ADDR)) |-> (rdata[4] && rdata[0] == drdy_i)); // R2
  AST_MEM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_q[2] && !srst) |=> !stat_q[2]); // R4
  AST_BAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !legal && !srst) |=> !stat_q[1]); // R5
  AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !evt_dev_reset) |=> $stable(stat_q[1])); // R5
  AST_PWRDN_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn |=> !stat_q[6]); // R6
  AST_MEM_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_mem_fault && !srst) |=> !fault_n); // R7
  AST_CMD_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd |=> (rst_req_o && stat_q[7:1] == 7'h1F)); // R8
  AST_NO_STRAY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd |=> !rst_req_o); // R8
  AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ref_uv && !srst) |=> !stat_q[5]); // R10
endmodule

bind actlow_status_reg actlow_status_chk #(
  .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .CTRL_ADDR(CTRL_ADDR),
  .WR_HI(WR_HI), .RST_CODE(RST_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .drdy_i(drdy_i), .evt_dev_reset(evt_dev_reset),
  .evt_ref_uv(evt_ref_uv), .evt_mem_fault(evt_mem_fault), .pwrdn(pwrdn),
  .fault_n(fault_n), .rst_req_o(rst_req_o), .stat_q(stat_q)
);

// File: tb/tb_actlow_status_reg.sv
module tb_actlow_status_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h02;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       drdy_i = 1'b0;
  logic       evt_dev_reset = 1'b0, evt_supply_uv = 1'b0, evt_ref_uv = 1'b0;
  logic       evt_crc_fault = 1'b0, evt_mem_fault = 1'b0, pwrdn = 1'b0;
  logic       fault_n, rst_req_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  actlow_status_reg dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .drdy_i(drdy_i), .evt_dev_reset(evt_dev_reset),
    .evt_supply_uv(evt_supply_uv), .evt_ref_uv(evt_ref_uv),
    .evt_crc_fault(evt_crc_fault), .evt_mem_fault(evt_mem_fault),
    .pwrdn(pwrdn), .fault_n(fault_n), .rst_req_o(rst_req_o)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic stat(input string tag, input logic [7:0] exp);
    addr = 8'h02;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 8'h02;
  endtask

  task automatic t_reset();
    stat("R1 reset value", 8'h3E);
    check("R7 fault pin after reset", {7'h0, fault_n}, 8'h00);
    check("R8 no request after reset", {7'h0, rst_req_o}, 8'h00);
  endtask

  task automatic t_drdy();
    drdy_i = 1'b1;
    stat("R2 data-ready mirrored", 8'h3F);
    drdy_i = 1'b0;
    stat("R2 data-ready low", 8'h3E);
  endtask

  task automatic t_restore();
    wr(8'h02, 8'h00);
    stat("R3 write zero no effect", 8'h3E);
    wr(8'h02, 8'hFF);
    stat("R3 write one restores", 8'hFE);
    check("R7 pin high all clear", {7'h0, fault_n}, 8'h01);
  endtask

  task automatic t_priority();
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h02; wdata = 8'h20; evt_ref_uv = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; evt_ref_uv = 1'b0;
    stat("R10 event beats restore", 8'hDE);
    check("R7 pin low on reference", {7'h0, fault_n}, 8'h00);
    wr(8'h02, 8'h20);
    stat("R3 reference restored", 8'hFE);
  endtask

  task automatic t_badwrite();
    wr(8'h01, 8'h00);
    stat("R5 write to 01h", 8'hFC);
    addr = 8'h01;
    #1;
    check("R9 read 01h zero", rdata, 8'h00);
    @(negedge clk);
    stat("R5 read leaves flag", 8'hFC);
    wr(8'h07, 8'hAA);
    stat("R5 legal write 07h", 8'hFE);
    wr(8'h10, 8'h00);
    stat("R5 write above 0Fh", 8'hFC);
    wr(8'h0F, 8'h00);
    stat("R5 legal write 0Fh", 8'hFE);
    wr(8'h03, 8'h00);
    stat("R5 write to 03h", 8'hFC);
    wr(8'h02, 8'h00);
    stat("R5 status write legal", 8'hFE);
  endtask

  task automatic t_crc_supply();
    @(negedge clk); evt_crc_fault = 1'b1;
    @(negedge clk); evt_crc_fault = 1'b0;
    stat("R7 crc event", 8'hF6);
    check("R7 pin low on crc", {7'h0, fault_n}, 8'h00);
    wr(8'h02, 8'h08);
    @(negedge clk); evt_supply_uv = 1'b1;
    @(negedge clk); evt_supply_uv = 1'b0;
    stat("R3 supply event", 8'hBE);
    wr(8'h02, 8'h40);
    stat("R3 supply restored", 8'hFE);
  endtask

  task automatic t_pwrdn();
    @(negedge clk); pwrdn = 1'b1;
    @(negedge clk);
    stat("R6 power-down forces supply", 8'hBE);
    wr(8'h02, 8'h40);
    stat("R6 restore blocked in power-down", 8'hBE);
    pwrdn = 1'b0;
    wr(8'h02, 8'h40);
    stat("R6 restore after power-down", 8'hFE);
  endtask

  task automatic t_mem();
    @(negedge clk); evt_mem_fault = 1'b1;
    @(negedge clk); evt_mem_fault = 1'b0;
    stat("R4 memory event", 8'hFA);
    wr(8'h02, 8'hFF);
    stat("R4 memory flag sticky", 8'hFA);
    check("R7 pin low on memory", {7'h0, fault_n}, 8'h00);
  endtask

  task automatic t_cmd();
    wr(8'h04, 8'h5A);
    check("R8 near-miss 5Ah no request", {7'h0, rst_req_o}, 8'h00);
    stat("R8 near-miss 5Ah no reset", 8'hFA);
    wr(8'h04, 8'h59);
    check("R8 near-miss 59h no request", {7'h0, rst_req_o}, 8'h00);
    wr(8'h04, 8'h58);
    check("R8 request pulse", {7'h0, rst_req_o}, 8'h01);
    stat("R8 status back to reset", 8'h3E);
    @(negedge clk);
    check("R8 request one cycle", {7'h0, rst_req_o}, 8'h00);
    addr = 8'h04;
    #1;
    check("R9 control reads zero", rdata, 8'h00);
    addr = 8'h02;
  endtask

  task automatic t_devrst();
    wr(8'h02, 8'hFF);
    stat("R11 cleared before reset", 8'hFE);
    @(negedge clk);
    evt_dev_reset = 1'b1; evt_mem_fault = 1'b1; evt_ref_uv = 1'b1;
    @(negedge clk);
    evt_dev_reset = 1'b0; evt_mem_fault = 1'b0; evt_ref_uv = 1'b0;
    stat("R11 R10 reset event beats events", 8'h3E);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_drdy();
    t_restore();
    t_priority();
    t_badwrite();
    t_crc_supply();
    t_pwrdn();
    t_mem();
    t_cmd();
    t_devrst();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule